// File: doc/BRIEF.md
# Timer Clock Source Selector

This block turns a 3-bit source code into a single-cycle count-enable strobe for a timer that lives elsewhere. The strobe can be held off, asserted every system clock, derived from one of four power-of-two taps of a free-running prescaler, or derived from one chosen polarity of transitions on an external pin.

The prescaler runs from reset and keeps running no matter which source is selected. Changing the code therefore never disturbs its phase. A two-flop synchronizer and a history flop watch the external pin in every mode. The pin is sampled whatever is driving it, so the block has no direction input. If the pin is driven by the chip itself, software can step the timer by toggling it. The strobe leaves the block through a register, so it depends on the code that is present at the clock edge that produces it.

Top module: `tick_source_sel`

## Requirements
- R1: While reset is asserted count_en is low. Reset clears the prescaler and the pin synchronizer, so in a divided mode the first edge after release already produces a strobe.
- R2: Code 000 produces no strobe at all.
- R3: Code 001 holds count_en high after every clock edge.
- R4: Codes 010, 011, 100 and 101 divide by N = 8, 64, 256 and 1024. Number the clock edges from 1 at the first edge after reset release. count_en is high after edge n exactly when (n-1) mod N = 0, and each strobe lasts one cycle.
- R5: Code 111 counts rising pin transitions. A transition made between clock edges gives one strobe, visible after the third following clock edge.
- R6: Code 110 counts falling pin transitions, with the same latency as R5.
- R7: A steady pin gives no strobe. A pin transition of the polarity that is not selected gives none either.
- R8: A new code governs the very next clock edge. It never resets or shifts the prescaler phase defined in R4.
- R9: The pin edge detector runs in every mode. A transition is counted if, at the edge that would emit its strobe, the code selects its polarity. It is dropped if the code has moved away by then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Source code (000 off, 001 undivided, 010-101 divided, 110 pin falling, 111 pin rising) |
| ext_pin | input | 1 | Asynchronous external count pin |
| count_en | output | 1 | One-cycle count-enable strobe |

## Verification
Two events can land on the same clock edge. A code change can arrive on the edge where a prescaler tap wraps. It can also arrive on the edge where a detected pin transition is due to emit its strobe. The first case is provoked by hopping through all codes every 37 cycles. The expected strobe then comes from the code registered at that edge and the edge number since reset. The second case is provoked by switching the code one or two cycles after a pin transition. The bench expects a strobe only when the code at the emitting edge selects that transition's polarity.

// File: rtl/tick_sel_pkg.sv
package tick_sel_pkg;

    localparam int SEL_W  = 3;
    localparam int PRE_W  = 10;
    localparam int N_TAPS = 4;

    typedef enum logic [SEL_W-1:0] {
        SRC_OFF      = 3'b000,
        SRC_SYS      = 3'b001,
        SRC_DIV8     = 3'b010,
        SRC_DIV64    = 3'b011,
        SRC_DIV256   = 3'b100,
        SRC_DIV1024  = 3'b101,
        SRC_PIN_FALL = 3'b110,
        SRC_PIN_RISE = 3'b111
    } src_sel_e;

    // log2 of the division ratio for tap index i (8, 64, 256, 1024)
    function automatic int tap_log2(input int i);
        case (i)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import tick_sel_pkg::*;
#(
    parameter int CNT_W    = PRE_W,
    parameter int TAP_CNT  = N_TAPS
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [TAP_CNT-1:0] wrap_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.cnt = state_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign cnt_o = state_q.cnt;

    // each tap fires when its low bits are all zero
    for (genvar i = 0; i < TAP_CNT; i++) begin : g_tap
        localparam int LOG = tap_log2(i);
        assign wrap_o[i] = (state_q.cnt[LOG-1:0] == '0);
    end

endmodule

// File: rtl/pin_edge_detect.sv
module pin_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o,
    output logic sync_o,
    output logic hist_o
);

    localparam int PIPE_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [PIPE_W-1:0] pipe;
    } det_state_t;

    det_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.pipe = {state_q.pipe[PIPE_W-2:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign sync_o = state_q.pipe[SYNC_STAGES-1];
    assign hist_o = state_q.pipe[SYNC_STAGES];
    assign rise_o = sync_o & ~hist_o;
    assign fall_o = ~sync_o & hist_o;

endmodule

// File: rtl/tick_mux.sv
module tick_mux
    import tick_sel_pkg::*;
(
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [N_TAPS-1:0] wrap_i,
    input  logic              rise_i,
    input  logic              fall_i,
    output logic              en_o
);

    always_comb begin
        en_o = 1'b0;
        case (sel_i)
            SRC_OFF:      en_o = 1'b0;
            SRC_SYS:      en_o = 1'b1;
            SRC_DIV8:     en_o = wrap_i[0];
            SRC_DIV64:    en_o = wrap_i[1];
            SRC_DIV256:   en_o = wrap_i[2];
            SRC_DIV1024:  en_o = wrap_i[3];
            SRC_PIN_FALL: en_o = fall_i;
            SRC_PIN_RISE: en_o = rise_i;
            default:      en_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tick_source_sel.sv
module tick_source_sel
    import tick_sel_pkg::*;
#(
    parameter int PRE_BITS   = PRE_W,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             ext_pin,
    output logic             count_en
);

    typedef struct packed {
        logic tick;
    } top_state_t;

    top_state_t           state_d, state_q;
    logic [PRE_BITS-1:0]  pre_cnt;
    logic [N_TAPS-1:0]    tap_wrap;
    logic                 pin_rise, pin_fall, pin_sync, pin_hist;
    logic                 en_next;

    tick_prescaler #(.CNT_W(PRE_BITS), .TAP_CNT(N_TAPS)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_o  (pre_cnt),
        .wrap_o (tap_wrap)
    );

    pin_edge_detect #(.SYNC_STAGES(SYNC_DEPTH)) u_pin (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin),
        .rise_o (pin_rise),
        .fall_o (pin_fall),
        .sync_o (pin_sync),
        .hist_o (pin_hist)
    );

    tick_mux u_mux (
        .sel_i  (clk_sel),
        .wrap_i (tap_wrap),
        .rise_i (pin_rise),
        .fall_i (pin_fall),
        .en_o   (en_next)
    );

    always_comb begin
        state_d      = state_q;
        state_d.tick = en_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign count_en = state_q.tick;

endmodule

// File: rtl/tick_source_sel_chk.sv
module tick_source_sel_chk #(
    parameter int PRE_BITS = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          sel,
    input logic                tick,
    input logic [PRE_BITS-1:0] pre_cnt,
    input logic                pin_sync,
    input logic                pin_hist
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> !tick);

    // R2
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(sel) == 3'b000) |-> !tick);

    // R3
    sys_every_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(sel) == 3'b001) |-> tick);

    // R4
    div8_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && tick && $past(sel) == 3'b010) |-> ($past(pre_cnt[2:0]) == 3'd0));

    // R4
    div1024_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && tick && $past(sel) == 3'b101) |-> ($past(pre_cnt) == '0));

    // R5
    rise_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && tick && $past(sel) == 3'b111) |-> ($past(pin_sync) && !$past(pin_hist)));

    // R6
    fall_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && tick && $past(sel) == 3'b110) |-> (!$past(pin_sync) && $past(pin_hist)));

    // R8
    pre_free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (pre_cnt == PRE_BITS'($past(pre_cnt) + 1'b1)));

endmodule

bind tick_source_sel tick_source_sel_chk #(.PRE_BITS(PRE_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (clk_sel),
    .tick     (count_en),
    .pre_cnt  (pre_cnt),
    .pin_sync (pin_sync),
    .pin_hist (pin_hist)
);

// File: tb/tick_source_sel_tb.sv
`timescale 1ns/1ps
module tick_source_sel_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] sel;
    logic       pin;
    logic       count_en;

    int         cyc;
    logic [2:0] sel_at_edge;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    tick_source_sel u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_sel  (sel),
        .ext_pin  (pin),
        .count_en (count_en)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
        sel_at_edge <= sel;
    end

    task automatic check(input bit exp, input string req);
        n_checks++;
        if (count_en !== exp) begin
            n_fail++;
            $display("FAIL %s: count_en=%b expected %b at edge %0d", req, count_en, exp, cyc);
        end
    endtask

    // expected strobe for codes 000..101 after edge n
    function automatic bit exp_fixed(input logic [2:0] s, input int n);
        case (s)
            3'b000:  return 1'b0;
            3'b001:  return 1'b1;
            3'b010:  return ((n - 1) % 8) == 0;
            3'b011:  return ((n - 1) % 64) == 0;
            3'b100:  return ((n - 1) % 256) == 0;
            3'b101:  return ((n - 1) % 1024) == 0;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check_span(input int n, input int hop);
        string tag;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (hop > 0)                 tag = "R8";
            else if (sel_at_edge == 3'b000) tag = "R2";
            else if (sel_at_edge == 3'b001) tag = "R3";
            else                         tag = "R4";
            check(exp_fixed(sel_at_edge, cyc), tag);
            if (hop > 0 && (cyc % hop) == 0)
                sel = (sel == 3'd5) ? 3'd0 : sel + 3'd1;
        end
    endtask

    task automatic pin_step(input bit newv, input int sw_k, input logic [2:0] sw_sel);
        bit    exp;
        string tag;
        pin = newv;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            exp = (k == 3) && ((sel_at_edge == 3'b111 && newv) ||
                               (sel_at_edge == 3'b110 && !newv));
            if (sw_k != 0) tag = "R9";
            else if (exp)  tag = newv ? "R5" : "R6";
            else           tag = "R7";
            check(exp, tag);
            if (k == sw_k) sel = sw_sel;
        end
    endtask

    initial begin
        rst_n = 1'b0;
        sel   = 3'b010;
        pin   = 1'b0;
        repeat (5) begin
            @(negedge clk);
            check(1'b0, "R1");
        end
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b1, "R1");
        check_span(300, 0);

        for (int s = 0; s < 6; s++) begin
            sel = 3'(s);
            check_span(2100, 0);
        end

        sel = 3'b011;
        check_span(1500, 37);

        sel = 3'b111;
        repeat (4) begin
            @(negedge clk);
            check(1'b0, "R7");
        end
        pin_step(1'b1, 0, 3'b111);
        pin_step(1'b0, 0, 3'b111);
        sel = 3'b110;
        pin_step(1'b1, 0, 3'b110);
        pin_step(1'b0, 0, 3'b110);
        pin_step(1'b1, 1, 3'b111);
        pin_step(1'b0, 1, 3'b110);
        sel = 3'b111;
        pin_step(1'b1, 2, 3'b000);
        pin_step(1'b0, 0, 3'b000);
        pin_step(1'b1, 0, 3'b000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule